// File: doc/BRIEF.md
# Differential Phase Symbol Decoder with Serial Output

This block undoes a four-state differential phase encoding. Each received symbol is a Gray-coded phase index. The block keeps the last accepted symbol as its phase reference. The information it recovers is the phase step from that reference to the new symbol, and this step is returned as a Gray-coded data word. After every decode the new symbol becomes the reference for the next one. The first symbol after reset is measured against a reference of zero.

The whole block runs on one bit clock. A symbol is offered by raising `sym_en_i` for one cycle, and symbols arrive no more often than once every `SYM_W` cycles. The decoded word is presented in parallel with a one-cycle strobe. It is then shifted out serially, most significant bit first, on the bit clock, with a valid flag for each bit. With the default width of two, the most significant bit is the I bit and the least significant bit is the Q bit. Carrier recovery and phase detection are done elsewhere.

Top module: `dqpsk_diff_decoder`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `dec_valid_o`, `ser_valid_o` and `dec_o` are all 0. The reference is cleared to 00.
- R2: The first symbol accepted after reset is decoded against reference 00, so the decoded word equals the symbol.
- R3: Symbol codes map to phase indices 00→0, 01→1, 11→2 and 10→3. The decoded word is the code whose phase index equals (phase(current) − phase(reference)) mod 4. For example, with reference 01 the current symbols 01, 11, 00 and 10 decode to 00, 01, 10 and 11.
- R4: A symbol is accepted only in a cycle where `sym_en_i` is high. In any other cycle `sym_i` has no effect: `dec_o` holds its value, no strobe is produced, and the reference does not change.
- R5: The edge that accepts a symbol also registers its decoded word. So `dec_valid_o` is high for exactly the one cycle after `sym_en_i`, and `dec_o` keeps its value until the next decode.
- R6: Each decoded word is shifted out on `ser_bit_o` bit [1] (I) first and then bit [0] (Q), in consecutive cycles. `ser_valid_o` is high for the first bit in the cycle after `dec_valid_o`.
- R7: When symbols arrive every second cycle, the serial stream has no gaps: `ser_valid_o` stays high from the first bit of a burst to the last bit.
- R8: With no pending bits, `ser_valid_o` is 0. When symbols are separated by at least one idle cycle beyond the minimum spacing, each word forms its own separate valid run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sym_en_i | input | 1 | Accept strobe for `sym_i` |
| sym_i | input | SYM_W | Received Gray-coded phase symbol |
| dec_o | output | SYM_W | Last decoded data word (bit 1 = I, bit 0 = Q) |
| dec_valid_o | output | 1 | One-cycle strobe marking a new `dec_o` |
| ser_bit_o | output | 1 | Serial data bit, MSB of each word first |
| ser_valid_o | output | 1 | High while `ser_bit_o` carries a data bit |

## Verification
The serializer can receive a new word in the same cycle that it shifts out the last bit of the previous word. A reference update can also coincide with that reload. Back-to-back symbols at the minimum spacing force this collision every second cycle. The scoreboard then requires every queued bit to appear in order. A counter of rising edges of `ser_valid_o` must show a single run for the whole burst. A separate pass with one extra idle cycle between symbols must show one run per word, which confirms that the reload path and the drain path are told apart.

// File: rtl/dqpsk_dec_pkg.sv
package dqpsk_dec_pkg;

    // widest symbol the helper functions handle
    localparam int unsigned MAX_SYM_W = 8;

    typedef logic [MAX_SYM_W-1:0] wide_code_t;

    // serializer occupancy state
    typedef enum logic [1:0] {
        SER_IDLE  = 2'd0,
        SER_SHIFT = 2'd1,
        SER_LAST  = 2'd2
    } ser_mode_e;

    // decoded word together with its strobe
    typedef struct packed {
        logic       vld;
        wide_code_t word;
    } dec_beat_t;

    function automatic wide_code_t gray_to_index(wide_code_t g, int unsigned w);
        wide_code_t b;
        b = '0;
        for (int i = MAX_SYM_W - 1; i >= 0; i--) begin
            if (i < int'(w)) begin
                if (i == int'(w) - 1) b[i] = g[i];
                else                  b[i] = b[i+1] ^ g[i];
            end
        end
        return b;
    endfunction

    function automatic wide_code_t index_to_gray(wide_code_t b, int unsigned w);
        wide_code_t mask;
        mask = wide_code_t'((1 << w) - 1);
        return (b ^ (b >> 1)) & mask;
    endfunction

    // decoded word for a step from reference code to current code
    function automatic wide_code_t step_decode(wide_code_t ref_c, wide_code_t cur_c,
                                               int unsigned w);
        wide_code_t mask;
        wide_code_t diff;
        mask = wide_code_t'((1 << w) - 1);
        diff = (gray_to_index(cur_c, w) - gray_to_index(ref_c, w)) & mask;
        return index_to_gray(diff, w);
    endfunction

endpackage

// File: rtl/dqpsk_gray_phase.sv
module dqpsk_gray_phase #(
    parameter int unsigned SYM_W = 2
) (
    input  logic [SYM_W-1:0] code_i,
    output logic [SYM_W-1:0] phase_o
);
    // running XOR from the MSB down turns a Gray code into a phase index
    always_comb begin
        phase_o[SYM_W-1] = code_i[SYM_W-1];
        for (int i = int'(SYM_W) - 2; i >= 0; i--) begin
            phase_o[i] = phase_o[i+1] ^ code_i[i];
        end
    end
endmodule

// File: rtl/dqpsk_ref_stage.sv
module dqpsk_ref_stage #(
    parameter int unsigned SYM_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sym_en_i,
    input  logic [SYM_W-1:0] sym_i,
    output logic [SYM_W-1:0] word_o,
    output logic             word_vld_o
);
    logic [SYM_W-1:0] ref_q;
    logic [SYM_W-1:0] ph_cur;
    logic [SYM_W-1:0] ph_ref;
    logic [SYM_W-1:0] ph_step;
    logic [SYM_W-1:0] step_gray;

    dqpsk_gray_phase #(.SYM_W(SYM_W)) u_ph_cur (
        .code_i  (sym_i),
        .phase_o (ph_cur)
    );

    dqpsk_gray_phase #(.SYM_W(SYM_W)) u_ph_ref (
        .code_i  (ref_q),
        .phase_o (ph_ref)
    );

    // modular phase step, then back to the Gray data code
    always_comb begin
        ph_step   = ph_cur - ph_ref;
        step_gray = ph_step ^ (ph_step >> 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q      <= '0;
            word_o     <= '0;
            word_vld_o <= 1'b0;
        end else begin
            word_vld_o <= sym_en_i;
            if (sym_en_i) begin
                ref_q  <= sym_i;
                word_o <= step_gray;
            end
        end
    end
endmodule

// File: rtl/dqpsk_bit_serializer.sv
module dqpsk_bit_serializer #(
    parameter int unsigned SYM_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [SYM_W-1:0] word_i,
    output logic             bit_o,
    output logic             bit_vld_o
);
    import dqpsk_dec_pkg::*;

    localparam int unsigned CNT_W = $clog2(SYM_W + 1);

    logic [SYM_W-1:0] shreg_q;
    logic [CNT_W-1:0] left_q;
    ser_mode_e        mode;

    always_comb begin
        if (left_q == '0)                mode = SER_IDLE;
        else if (left_q == CNT_W'(1))    mode = SER_LAST;
        else                             mode = SER_SHIFT;
    end

    // a load overrides the final shift so back-to-back words stay contiguous
    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_q <= '0;
            left_q  <= '0;
        end else if (load_i) begin
            shreg_q <= word_i;
            left_q  <= CNT_W'(SYM_W);
        end else if (mode != SER_IDLE) begin
            shreg_q <= {shreg_q[SYM_W-2:0], 1'b0};
            left_q  <= left_q - CNT_W'(1);
        end
    end

    assign bit_o     = shreg_q[SYM_W-1];
    assign bit_vld_o = (mode != SER_IDLE);
endmodule

// File: rtl/dqpsk_diff_decoder.sv
module dqpsk_diff_decoder #(
    parameter int unsigned SYM_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sym_en_i,
    input  logic [SYM_W-1:0] sym_i,
    output logic [SYM_W-1:0] dec_o,
    output logic             dec_valid_o,
    output logic             ser_bit_o,
    output logic             ser_valid_o
);
    logic [SYM_W-1:0] word;
    logic             word_vld;

    dqpsk_ref_stage #(.SYM_W(SYM_W)) u_ref (
        .clk        (clk),
        .rst        (rst),
        .sym_en_i   (sym_en_i),
        .sym_i      (sym_i),
        .word_o     (word),
        .word_vld_o (word_vld)
    );

    dqpsk_bit_serializer #(.SYM_W(SYM_W)) u_ser (
        .clk       (clk),
        .rst       (rst),
        .load_i    (word_vld),
        .word_i    (word),
        .bit_o     (ser_bit_o),
        .bit_vld_o (ser_valid_o)
    );

    assign dec_o       = word;
    assign dec_valid_o = word_vld;
endmodule

// File: rtl/dqpsk_diff_decoder_chk.sv
module dqpsk_diff_decoder_chk #(
    parameter int unsigned SYM_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             sym_en_i,
    input logic [SYM_W-1:0] sym_i,
    input logic [SYM_W-1:0] dec_o,
    input logic             dec_valid_o,
    input logic             ser_bit_o,
    input logic             ser_valid_o
);
    import dqpsk_dec_pkg::*;

    logic [SYM_W-1:0] shadow_ref;
    logic [SYM_W-1:0] shadow_exp;
    logic             past_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_ref <= '0;
            shadow_exp <= '0;
            past_ok    <= 1'b0;
        end else begin
            past_ok <= 1'b1;
            if (sym_en_i) begin
                shadow_ref <= sym_i;
                shadow_exp <= SYM_W'(step_decode(wide_code_t'(shadow_ref),
                                                 wide_code_t'(sym_i), SYM_W));
            end
        end
    end

    a_r5_strobe_after_accept: assert property (@(posedge clk) disable iff (rst)
        sym_en_i |=> dec_valid_o);

    a_r5_strobe_needs_accept: assert property (@(posedge clk) disable iff (rst)
        dec_valid_o |-> $past(sym_en_i));

    a_r3_decoded_word: assert property (@(posedge clk) disable iff (rst)
        dec_valid_o |-> (dec_o == shadow_exp));

    a_r4_word_holds: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !dec_valid_o) |-> $stable(dec_o));

    a_r6_msb_first: assert property (@(posedge clk) disable iff (rst)
        dec_valid_o |=> (ser_valid_o && (ser_bit_o == $past(dec_o[SYM_W-1]))));
endmodule

bind dqpsk_diff_decoder dqpsk_diff_decoder_chk #(.SYM_W(SYM_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .sym_en_i    (sym_en_i),
    .sym_i       (sym_i),
    .dec_o       (dec_o),
    .dec_valid_o (dec_valid_o),
    .ser_bit_o   (ser_bit_o),
    .ser_valid_o (ser_valid_o)
);

// File: tb/dqpsk_diff_decoder_tb.sv
module dqpsk_diff_decoder_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sym_en = 1'b0;
    logic [1:0] sym = 2'b00;
    logic [1:0] dec;
    logic       dec_vld;
    logic       sbit;
    logic       svld;

    dqpsk_diff_decoder #(.SYM_W(2)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .sym_en_i    (sym_en),
        .sym_i       (sym),
        .dec_o       (dec),
        .dec_valid_o (dec_vld),
        .ser_bit_o   (sbit),
        .ser_valid_o (svld)
    );

    always #2 clk = ~clk;

    int         checks = 0;
    int         errors = 0;
    int         ser_rises = 0;
    logic       ser_prev = 1'b0;
    logic       exp_ser_next = 1'b0;
    logic [1:0] ref_m = 2'b00;
    logic [1:0] word_q[$];
    logic       bit_q[$];
    bit         done = 1'b0;

    // encoder model: next symbol from reference and data word
    function automatic logic [1:0] enc_f(logic [1:0] p, logic [1:0] d);
        case ({p, d})
            4'b0000: return 2'b00; 4'b0001: return 2'b01;
            4'b0010: return 2'b10; 4'b0011: return 2'b11;
            4'b0100: return 2'b01; 4'b0101: return 2'b11;
            4'b0110: return 2'b00; 4'b0111: return 2'b10;
            4'b1000: return 2'b10; 4'b1001: return 2'b00;
            4'b1010: return 2'b11; 4'b1011: return 2'b01;
            4'b1100: return 2'b11; 4'b1101: return 2'b10;
            4'b1110: return 2'b01; default: return 2'b00;
        endcase
    endfunction

    function automatic logic [1:0] inv_f(logic [1:0] p, logic [1:0] c);
        for (int d = 0; d < 4; d++) begin
            if (enc_f(p, 2'(d)) == c) return 2'(d);
        end
        return 2'b00;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // monitor: pops the scoreboard as results appear
    always @(negedge clk) begin
        if (rst) begin
            ser_prev     <= 1'b0;
            exp_ser_next <= 1'b0;
        end else if (!done) begin
            if (exp_ser_next) chk(svld == 1'b1, "R6 first bit timing", int'(svld), 1);
            if (dec_vld) begin
                if (word_q.size() == 0) chk(1'b0, "R4 unexpected strobe", 1, 0);
                else begin
                    logic [1:0] e;
                    e = word_q.pop_front();
                    chk(dec == e, "R3 decoded word", int'(dec), int'(e));
                end
            end
            if (svld) begin
                if (bit_q.size() == 0) chk(1'b0, "R8 unexpected serial bit", 1, 0);
                else begin
                    logic eb;
                    eb = bit_q.pop_front();
                    chk(sbit == eb, "R6 serial bit order", int'(sbit), int'(eb));
                end
            end
            if (svld && !ser_prev) ser_rises++;
            ser_prev     <= svld;
            exp_ser_next <= dec_vld;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        sym_en = 1'b0;
        repeat (3) @(negedge clk);
        chk(dec_vld == 1'b0 && svld == 1'b0 && dec == 2'b00, "R1 reset state",
            int'({dec_vld, svld, dec}), 0);
        word_q.delete();
        bit_q.delete();
        ref_m = 2'b00;
        rst = 1'b0;
        @(negedge clk);
        chk(dec_vld == 1'b0 && svld == 1'b0 && dec == 2'b00, "R1 after release",
            int'({dec_vld, svld, dec}), 0);
    endtask

    // driver: accepts one symbol, then spends one cycle with junk on sym
    task automatic send_sym(logic [1:0] s);
        logic [1:0] e;
        @(negedge clk);
        sym_en = 1'b1;
        sym = s;
        e = inv_f(ref_m, s);
        ref_m = s;
        word_q.push_back(e);
        bit_q.push_back(e[1]);
        bit_q.push_back(e[0]);
        @(negedge clk);
        chk(dec_vld == 1'b1, "R5 strobe one cycle after accept", int'(dec_vld), 1);
        sym_en = 1'b0;
        sym = 2'($urandom);
    endtask

    task automatic send_data(logic [1:0] d);
        send_sym(enc_f(ref_m, d));
    endtask

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            sym = 2'($urandom);
        end
    endtask

    initial begin
        do_reset();

        // R2: first symbol against zero reference
        send_sym(2'b11);
        chk(dec == 2'b11, "R2 first symbol equals word", int'(dec), 3);
        idle(4);

        // R3: every reference/current pair
        for (int p = 0; p < 4; p++) begin
            for (int c = 0; c < 4; c++) begin
                send_sym(2'(p));
                send_sym(2'(c));
                idle(2);
            end
        end
        idle(3);

        // R4: junk on sym without accept leaves word and strobe alone
        begin
            logic [1:0] held;
            held = dec;
            idle(6);
            chk(dec == held && dec_vld == 1'b0, "R4 ignored input", int'(dec), int'(held));
        end
        send_data(2'b10);
        idle(3);

        // R7: back-to-back burst gives one valid run
        ser_rises = 0;
        for (int k = 0; k < 12; k++) send_data(2'($urandom));
        idle(4);
        chk(ser_rises == 1, "R7 contiguous burst", ser_rises, 1);

        // R8: spaced symbols give separate runs, idle when drained
        ser_rises = 0;
        for (int k = 0; k < 6; k++) begin
            send_data(2'($urandom));
            idle(1);
        end
        idle(4);
        chk(ser_rises == 6, "R8 separate runs", ser_rises, 6);
        chk(svld == 1'b0, "R8 idle low", int'(svld), 0);

        // random stream with random gaps
        for (int k = 0; k < 300; k++) begin
            send_data(2'($urandom));
            idle(int'($urandom_range(0, 2)));
        end
        idle(6);
        chk(word_q.size() == 0 && bit_q.size() == 0, "R6 stream fully delivered",
            word_q.size() + bit_q.size(), 0);

        // reset mid-traffic, then reference restarts at zero
        send_data(2'b01);
        do_reset();
        send_sym(2'b10);
        chk(dec == 2'b10, "R2 after second reset", int'(dec), 2);
        idle(4);
        chk(bit_q.size() == 0, "R6 drained after reset", bit_q.size(), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule